// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the line and frame timing for a display output. Each line and each frame is made of four segments: sync, back porch, active data and front porch. The length of every segment comes from a register. From two chained segment counters the block drives a horizontal sync, a vertical sync, a data-enable strobe and the coordinates of the pixel on screen. Each of the three timing outputs has its own polarity bit, and a command bit starts or halts the raster.

The block raises two events. A frame-start event is generated internally. An underrun pulse comes in from the pixel-fetch logic. Both events latch into a status register that is cleared by writing ones, and a mask selects which latched bits drive the interrupt line. A framebuffer base address can be rewritten while the raster runs. The new value waits in a shadow register and is handed to the fetch side only when a frame starts, so software can flip between two stacked screen buffers without tearing.

Configuration goes through a single-cycle write port with a 4-bit address. Fetching pixels from memory and generating the pixel clock are left to neighbouring blocks.

Top module: `raster_timing_gen`

## Requirements
- R1: Each interval register holds its segment length minus one. A segment programmed with value N lasts N+1 clocks (for vertical segments, N+1 lines). The horizontal registers sit at addresses 8 (sync), 9 (back porch), 10 (active) and 11 (front porch); the vertical registers sit at 12, 13, 14 and 15 in the same segment order.
- R2: While enabled, every line runs sync, then back porch, then active, then front porch, and then wraps back to sync. hsync is asserted exactly during the horizontal sync segment.
- R3: The vertical segments advance one step per line, in the same order, after the last clock of the horizontal front porch. vsync is asserted for whole lines during the vertical sync segment.
- R4: de_o is asserted only when both the horizontal and the vertical segment are active. While de_o is high, pix_x_o and pix_y_o give the zero-based column and row inside the active area; otherwise both read zero.
- R5: The polarity register at address 1 has bit 0 for hsync, bit 1 for vsync and bit 2 for de. A set bit makes that output active-high; a clear bit makes it active-low. After reset all three bits are set.
- R6: Bit 0 of the command register at address 4'd0 enables the raster when 1 and halts it when 0. While halted, both counters are held at zero and the three timing outputs sit at their inactive levels. After an enable, the first enabled clock is the first sync clock of line 0.
- R7: Status bit 0 sets on the first clock of each frame, which is the first clock of vertical sync. Status bit 1 sets on any clock where underrun_i is high. Both bits are visible on irq_status_o.
- R8: Writing to address 3 clears every status bit whose data bit is 1. If an event arrives in the same clock as the clear, the event wins and the bit stays set.
- R9: irq_o is high when any status bit is set together with its bit in the mask register at address 2 (bit 0 for frame start, bit 1 for underrun).
- R10: A write to address 4 stores the framebuffer base in a shadow register. fb_base_o takes the shadow value only on the first clock of a frame, using the value the shadow held before any write made in that same clock, and keeps its value on every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW (32) | Register write data |
| underrun_i | input | 1 | Underrun pulse from the pixel-fetch side |
| hsync_o | output | 1 | Horizontal sync, polarity per R5 |
| vsync_o | output | 1 | Vertical sync, polarity per R5 |
| de_o | output | 1 | Data enable, polarity per R5 |
| pix_x_o | output | CW (12) | Active column |
| pix_y_o | output | CW (12) | Active row |
| fb_base_o | output | FBW (32) | Framebuffer base in use for the current frame |
| irq_status_o | output | 2 | Latched events: bit 0 frame start, bit 1 underrun |
| irq_o | output | 1 | Masked interrupt request |

## Verification
The hardest cases are a clear or a base-address write that lands exactly on the first clock of a frame, because that clock comes only once per frame. The bench runs a behavioural position model and uses it to stop at the clock cycle just before the frame starts. There it drives a clear together with an underrun pulse, and in a later frame a base write, so that both the set-wins rule and the old-shadow rule are exercised. The full reference line length (1680 active pixels with 32/80/48 blanking) is run against a short frame so the run stays within budget.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC  = 2'd0,
      SEG_BACK  = 2'd1,
      SEG_ACT   = 2'd2,
      SEG_FRONT = 2'd3
   } seg_e;

   localparam logic [3:0] ADR_CMD  = 4'd0;
   localparam logic [3:0] ADR_POL  = 4'd1;
   localparam logic [3:0] ADR_MASK = 4'd2;
   localparam logic [3:0] ADR_CLR  = 4'd3;
   localparam logic [3:0] ADR_FB   = 4'd4;
   localparam int unsigned ADR_LEN_BASE = 8;

   localparam int unsigned EV_FRAME = 0;
   localparam int unsigned EV_UNDER = 1;
   localparam int unsigned NUM_EV   = 2;
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
   import rtg_pkg::*;
#(
   parameter int unsigned CW = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                step,
   input  logic [3:0][CW-1:0]  len,
   output seg_e                seg,
   output logic [CW-1:0]       cnt,
   output logic                wrap
);
   logic seg_done;

   assign seg_done = (cnt >= len[seg]);
   assign wrap     = run && step && seg_done && (seg == SEG_FRONT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg <= SEG_SYNC;
         cnt <= '0;
      end else if (!run) begin
         seg <= SEG_SYNC;
         cnt <= '0;
      end else if (step) begin
         if (seg_done) begin
            cnt <= '0;
            seg <= seg_e'(seg + 2'd1);
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R1 / R2: a finished segment restarts the count and moves to the next one
   assert_seg_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && seg_done) |=> (cnt == '0 && seg == seg_e'($past(seg) + 2'd1)));

   assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && step && !seg_done) |=> (cnt == $past(cnt) + 1'b1 && seg == $past(seg)));

   assert_halt_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (cnt == '0 && seg == SEG_SYNC));
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
   import rtg_pkg::*;
#(
   parameter int unsigned CW  = 12,
   parameter int unsigned FBW = 32,
   parameter int unsigned DW  = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [3:0]               wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic                     frame_start,
   output logic                     run,
   output logic [2:0]               pol,
   output logic [NUM_EV-1:0]        mask,
   output logic                     clr_stb,
   output logic [NUM_EV-1:0]        clr_bits,
   output logic [1:0][3:0][CW-1:0]  lens,
   output logic [FBW-1:0]           fb_active
);
   logic [FBW-1:0] fb_shadow;

   assign clr_stb  = wr_en && (wr_addr == ADR_CLR);
   assign clr_bits = wr_data[NUM_EV-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         pol       <= 3'b111;
         mask      <= '0;
         fb_shadow <= '0;
         fb_active <= '0;
      end else begin
         if (frame_start) fb_active <= fb_shadow;
         if (wr_en) begin
            case (wr_addr)
               ADR_CMD:  run       <= wr_data[0];
               ADR_POL:  pol       <= wr_data[2:0];
               ADR_MASK: mask      <= wr_data[NUM_EV-1:0];
               ADR_FB:   fb_shadow <= wr_data[FBW-1:0];
               default:  ;
            endcase
         end
      end
   end

   for (genvar ax = 0; ax < 2; ax++) begin : g_axis
      for (genvar s = 0; s < 4; s++) begin : g_seg
         localparam logic [3:0] MY_ADR = 4'(ADR_LEN_BASE + 4 * ax + s);
         logic [CW-1:0] len_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            len_q <= '0;
            else if (wr_en && wr_addr == MY_ADR)   len_q <= wr_data[CW-1:0];
         end
         assign lens[ax][s] = len_q;
      end
   end

   // R10: the base seen by the fetch side changes only at a frame start
   assert_fb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start) |=> (fb_active == $past(fb_active)));
endmodule

// File: rtl/rtg_irq.sv
module rtg_irq
   import rtg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] events,
   input  logic              clr_stb,
   input  logic [NUM_EV-1:0] clr_bits,
   input  logic [NUM_EV-1:0] mask,
   output logic [NUM_EV-1:0] status,
   output logic              irq
);
   logic [NUM_EV-1:0] keep;

   assign keep = clr_stb ? ~clr_bits : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & keep) | events;
   end

   assign irq = |(status & mask);

   assert_frame_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      events[EV_FRAME] |=> status[EV_FRAME]);

   assert_under_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      events[EV_UNDER] |=> status[EV_UNDER]);

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && clr_bits[EV_UNDER] && !events[EV_UNDER]) |=> !status[EV_UNDER]);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int unsigned CW  = 12,
   parameter int unsigned FBW = 32,
   parameter int unsigned DW  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic              underrun_i,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic [CW-1:0]     pix_x_o,
   output logic [CW-1:0]     pix_y_o,
   output logic [FBW-1:0]    fb_base_o,
   output logic [1:0]        irq_status_o,
   output logic              irq_o
);
   initial begin
      assert (CW >= 2 && CW <= DW && FBW <= DW && DW >= 3)
         else $error("raster_timing_gen: illegal width parameters");
   end

   logic                     run;
   logic [2:0]               pol;
   logic [NUM_EV-1:0]        mask, clr_bits, events;
   logic                     clr_stb;
   logic [1:0][3:0][CW-1:0]  lens;
   seg_e                     h_seg, v_seg;
   logic [CW-1:0]            h_cnt, v_cnt;
   logic                     h_wrap, v_wrap;
   logic                     frame_start;
   logic                     h_on, v_on, act_on;

   rtg_regs #(.CW(CW), .FBW(FBW), .DW(DW)) i_regs (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
      .frame_start, .run, .pol, .mask, .clr_stb, .clr_bits,
      .lens, .fb_active(fb_base_o)
   );

   rtg_axis #(.CW(CW)) i_h_axis (
      .clk, .rst_n, .run, .step(1'b1), .len(lens[0]),
      .seg(h_seg), .cnt(h_cnt), .wrap(h_wrap)
   );

   rtg_axis #(.CW(CW)) i_v_axis (
      .clk, .rst_n, .run, .step(h_wrap), .len(lens[1]),
      .seg(v_seg), .cnt(v_cnt), .wrap(v_wrap)
   );

   assign frame_start = run && h_seg == SEG_SYNC && h_cnt == '0
                            && v_seg == SEG_SYNC && v_cnt == '0;

   assign events[EV_FRAME] = frame_start;
   assign events[EV_UNDER] = underrun_i;

   rtg_irq i_irq (
      .clk, .rst_n, .events, .clr_stb, .clr_bits, .mask,
      .status(irq_status_o), .irq(irq_o)
   );

   assign h_on   = run && (h_seg == SEG_SYNC);
   assign v_on   = run && (v_seg == SEG_SYNC);
   assign act_on = run && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);

   assign hsync_o = pol[0] ? h_on   : ~h_on;
   assign vsync_o = pol[1] ? v_on   : ~v_on;
   assign de_o    = pol[2] ? act_on : ~act_on;
   assign pix_x_o = act_on ? h_cnt : '0;
   assign pix_y_o = act_on ? v_cnt : '0;

   // R3: a frame wraps only on the last clock of a line
   assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      v_wrap |-> h_wrap);

   // R6: a halted raster presents no active pixel
   assert_halt_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run) |=> (pix_x_o == '0 && pix_y_o == '0));
endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
   localparam int CW = 12, FBW = 32, DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en, underrun_i;
   logic [3:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic hsync_o, vsync_o, de_o, irq_o;
   logic [CW-1:0] pix_x_o, pix_y_o;
   logic [FBW-1:0] fb_base_o;
   logic [1:0] irq_status_o;

   always #10 clk = ~clk;

   raster_timing_gen #(.CW(CW), .FBW(FBW), .DW(DW)) i_raster_timing_gen (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .underrun_i,
      .hsync_o, .vsync_o, .de_o, .pix_x_o, .pix_y_o,
      .fb_base_o, .irq_status_o, .irq_o
   );

   int nchk = 0, nfail = 0;
   bit done = 0;

   // behavioural reference: absolute positions inside line and frame
   int hl[4], vl[4];
   bit m_en;
   bit [2:0] m_pol;
   bit [1:0] m_mask, m_st;
   bit [31:0] m_fbs, m_fba;
   int hp, vp;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin hl[i] = 1; vl[i] = 1; end
         m_en = 0; m_pol = 3'b111; m_mask = 0; m_st = 0;
         m_fbs = 0; m_fba = 0; hp = 0; vp = 0;
      end else begin
         bit fs;
         fs = m_en && hp == 0 && vp == 0;
         if (fs) m_fba = m_fbs;
         if (wr_en && wr_addr == 4'd3) m_st = m_st & ~wr_data[1:0];
         m_st = m_st | {underrun_i, fs};
         if (m_en) begin
            hp++;
            if (hp == hl[0] + hl[1] + hl[2] + hl[3]) begin
               hp = 0;
               vp++;
               if (vp == vl[0] + vl[1] + vl[2] + vl[3]) vp = 0;
            end
         end else begin
            hp = 0; vp = 0;
         end
         if (wr_en) begin
            if (wr_addr == 4'd0) m_en = wr_data[0];
            else if (wr_addr == 4'd1) m_pol = wr_data[2:0];
            else if (wr_addr == 4'd2) m_mask = wr_data[1:0];
            else if (wr_addr == 4'd4) m_fbs = wr_data;
            else if (wr_addr >= 4'd8 && wr_addr <= 4'd11) hl[wr_addr - 8] = int'(wr_data[CW-1:0]) + 1;
            else if (wr_addr >= 4'd12) vl[wr_addr - 12] = int'(wr_data[CW-1:0]) + 1;
         end
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         bit hs_a, vs_a, ha, va, de_a;
         int xs, ys;
         xs = hl[0] + hl[1];
         ys = vl[0] + vl[1];
         hs_a = m_en && hp < hl[0];
         vs_a = m_en && vp < vl[0];
         ha = hp >= xs && hp < xs + hl[2];
         va = vp >= ys && vp < ys + vl[2];
         de_a = m_en && ha && va;
         chk("R1 R2 R5 R6", "hsync", hsync_o, m_pol[0] ? hs_a : !hs_a);
         chk("R3 R5 R6", "vsync", vsync_o, m_pol[1] ? vs_a : !vs_a);
         chk("R2 R4 R5", "de", de_o, m_pol[2] ? de_a : !de_a);
         chk("R4", "pix_x", pix_x_o, de_a ? hp - xs : 0);
         chk("R4", "pix_y", pix_y_o, de_a ? vp - ys : 0);
         chk("R10", "fb_base", fb_base_o, m_fba);
         chk("R7 R8", "status", irq_status_o, m_st);
         chk("R9", "irq", irq_o, |(m_st & m_mask));
      end
   end

   task automatic wr_now(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // stop at the negedge just before the first clock of a frame
   task automatic wait_frame_start();
      @(negedge clk);
      while (!(m_en && hp == 0 && vp == 0)) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wr_en = 0; wr_addr = 0; wr_data = 0; underrun_i = 0;
      idle(4);
      rst_n = 1;                              // reset state compared above
      // small mode for R1/R2/R3: H 3,2,6,2  V 2,1,4,2
      wr(4'd8, 2); wr(4'd9, 1); wr(4'd10, 5); wr(4'd11, 1);
      wr(4'd12, 1); wr(4'd13, 0); wr(4'd14, 3); wr(4'd15, 1);
      wr(4'd2, 3); wr(4'd4, 32'h1000);
      idle(6);                                // R10: no frame yet, base unchanged
      wr(4'd0, 1);                            // R6 enable
      idle(300);
      // R7 underrun, R8 clears
      @(negedge clk); underrun_i = 1; @(negedge clk); underrun_i = 0;
      idle(5); wr(4'd3, 2); idle(5); wr(4'd3, 1); idle(120);
      // R5 polarity variants
      wr(4'd1, 0); idle(250); wr(4'd1, 3'b101); idle(130);
      // R10 mid-frame base write
      idle(37); wr(4'd4, 32'h2000); idle(130);
      // R8 collision: clear and underrun on the frame-start clock
      wait_frame_start();
      underrun_i = 1;
      wr_now(4'd3, 3);
      underrun_i = 0;
      idle(20);
      // R10 collision: base write on the frame-start clock
      wait_frame_start();
      wr_now(4'd4, 32'h3000);
      idle(130);
      // R9 mask variants
      wr(4'd2, 0); idle(5); wr(4'd2, 2); idle(5); wr(4'd2, 1); idle(5);
      // R6 halt mid-frame and restart
      idle(41); wr(4'd0, 0); idle(20); wr(4'd0, 1); idle(130);
      // reference line length 32/80/1680/48 against the short frame
      wr(4'd0, 0);
      wr(4'd8, 31); wr(4'd9, 79); wr(4'd10, 1679); wr(4'd11, 47);
      wr(4'd3, 3);
      wr(4'd0, 1);
      idle(1840 * 9 + 50);
      finish_run();
   end
endmodule